// File: doc/BRIEF.md
# Region Memory Protection Unit

This block checks every memory access against eight programmable address regions. Each access carries an address, a privilege flag and an access type: data read, data write or instruction fetch. The unit finds the highest-numbered enabled region that covers the address. It then decides whether to allow or abort the access, and reports whether the location is cacheable and whether data writes may be buffered. The check is fully combinational from the access inputs. The result is registered and appears on the outputs one clock after the request.

A register port configures the unit. It holds the following state:
- a control word, which holds the global enable, the data-cache gate, the code-cache gate and the vector-base select;
- three per-region bitmasks: data-cacheable, code-cacheable and write-bufferable;
- two permission words of four bits per region, one for data and one for code;
- eight region descriptors.

Each permission word can also be accessed through a packed legacy view with two bits per region. Caches and exception handling sit outside this block.

Top module: `region_prot_unit`

## Requirements
- R1: After reset the control word reads 0x00002078 and `vec_base_o` is 0xFFFF0000. Every other register reads 0, and `chk_valid_o` is low.
- R2: A write to the control word (select 0) changes only the bits set in 0x000FF085. Bit 0 enables protection, bit 2 gates data caching and bit 12 gates code caching. Bit 13 selects `vec_base_o` = 0xFFFF0000 (set) or 0 (clear).
- R3: A region descriptor (select 8, region chosen by `cfg_idx_i`) has three fields: bit 0 enables the region, bits 5:1 hold a size exponent N, and bits 31:12 hold the base page. An enabled region covers addresses from base*4096 up to, but not including, base*4096 + (2<<N). Matching is done in 4 KB pages, so a region with N < 11 covers nothing.
- R4: When enabled regions overlap, the highest-numbered region decides all attributes, and its index appears on `chk_region_o` with `chk_hit_o` high.
- R5: Data access codes sit at bits 4i+3:4i of the data permission word (select 4) for region i. The codes are:
  - code 1: privileged read and write only;
  - code 2: privileged read and write, plus user read;
  - code 3: read and write in both modes;
  - code 5: privileged read only;
  - code 6: read only in both modes;
  - code 0 and every other value: no data access.
- R6: Fetch codes use the same layout in the code permission word (select 5). Codes 1 and 5 allow a privileged fetch only. Codes 2, 3 and 6 allow fetch in both modes. All other codes deny the fetch.
- R7: With protection enabled, an address that no enabled region covers is aborted for every access type, with both cache attributes low.
- R8: The legacy views (select 6 for data, select 7 for code) hold two bits per region. On a write, bits 2i+1:2i go to bits 4i+1:4i of the full word and bits 4i+3:4i+2 are cleared. On a read, the legacy view returns bits 4i+1:4i packed back into bits 2i+1:2i.
- R9: The cache attributes depend on the access type:
  - For a data access, `chk_cacheable_o` = control bit 2 AND the region's bit in the data-cacheable mask (select 1). `chk_bufferable_o` = that value AND the region's bit in the write-buffer mask (select 3).
  - For a fetch, `chk_cacheable_o` = control bit 12 AND the region's bit in the code-cacheable mask (select 2), and `chk_bufferable_o` is 0.
- R10: With control bit 0 clear, every access is allowed. A data access then reports cacheable and bufferable both equal to control bit 2. A fetch reports cacheable equal to control bit 12, with bufferable 0, hit 0 and region 0.
- R11: `chk_valid_o` is high exactly one clock after a cycle with `acc_valid_i` high. The other check outputs describe that request.
- R12: Writes to selects 9 to 15 change no register, and reads of those selects return 0. `acc_type_i` is encoded as 0 = read, 1 = write, 2 = fetch, and 3 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 4 | Register select |
| cfg_idx_i | input | 3 | Region index for descriptor access |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| acc_valid_i | input | 1 | Access request valid |
| acc_addr_i | input | 32 | Access byte address |
| acc_priv_i | input | 1 | 1 = privileged, 0 = user |
| acc_type_i | input | 2 | Access type |
| chk_valid_o | output | 1 | Check result valid |
| chk_abort_o | output | 1 | Access must abort |
| chk_cacheable_o | output | 1 | Location is cacheable for this access |
| chk_bufferable_o | output | 1 | Data write may be buffered |
| chk_hit_o | output | 1 | An enabled region covered the address |
| chk_region_o | output | 3 | Winning region index |
| vec_base_o | output | 32 | Exception vector base |

## Verification
The hardest case to reach from the ports is an address that several enabled regions cover at once, sitting on the exact page boundary of the winning region. Another hard case is a region whose end lies beyond the top of the address space. To reach these, the stimulus builds a nested layout: a full-space background region, a 16 MB window, a 4 KB page and a high-half region with the largest size exponent. It then probes the first and last page of each region. After that it sweeps all sixteen access codes through one overlapping region, for every access type and privilege. Finally it sends seeded random addresses drawn from around those boundaries.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [3:0] SEL_CTRL   = 4'd0;
  localparam logic [3:0] SEL_DCACHE = 4'd1;
  localparam logic [3:0] SEL_ICACHE = 4'd2;
  localparam logic [3:0] SEL_WBUF   = 4'd3;
  localparam logic [3:0] SEL_DPERM  = 4'd4;
  localparam logic [3:0] SEL_CPERM  = 4'd5;
  localparam logic [3:0] SEL_DLEG   = 4'd6;
  localparam logic [3:0] SEL_CLEG   = 4'd7;
  localparam logic [3:0] SEL_RGN    = 4'd8;

  localparam logic [DW-1:0] CTRL_WMASK = 32'h000F_F085;
  localparam logic [DW-1:0] CTRL_RST   = 32'h0000_2078;
  localparam logic [DW-1:0] VEC_HIGH   = 32'hFFFF_0000;

  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_DCACHE = 2;
  localparam int unsigned BIT_ICACHE = 12;
  localparam int unsigned BIT_VEC    = 13;

  localparam int unsigned PAGE_W  = 12;
  localparam int unsigned MIN_EXP = 11;  // 2<<11 = one page
endpackage

// File: rtl/mpu_regs.sv
module mpu_regs
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_RGN = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_RGN),
  localparam int unsigned PERM_W = 4 * NUM_RGN
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [3:0]             sel_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [DW-1:0]          ctrl_o,
  output logic [NUM_RGN-1:0]     dcache_o,
  output logic [NUM_RGN-1:0]     icache_o,
  output logic [NUM_RGN-1:0]     wbuf_o,
  output logic [PERM_W-1:0]      dperm_o,
  output logic [PERM_W-1:0]      cperm_o,
  output logic [NUM_RGN-1:0][DW-1:0] rgn_o
);
  localparam logic [PERM_W-1:0] LEG_HI = {NUM_RGN{4'b1100}};

  logic [DW-1:0]      ctrl_q;
  logic [NUM_RGN-1:0] dcache_q, icache_q, wbuf_q;
  logic [PERM_W-1:0]  dperm_q, cperm_q;
  logic [PERM_W-1:0]  leg_wr;
  logic [2*NUM_RGN-1:0] dleg_rd, cleg_rd;

  always_comb begin
    leg_wr = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      leg_wr[4*i +: 2] = wdata_i[2*i +: 2];
      dleg_rd[2*i +: 2] = dperm_q[4*i +: 2];
      cleg_rd[2*i +: 2] = cperm_q[4*i +: 2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      dcache_q <= '0;
      icache_q <= '0;
      wbuf_q   <= '0;
      dperm_q  <= '0;
      cperm_q  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_CTRL:   ctrl_q   <= (ctrl_q & ~CTRL_WMASK) | (wdata_i & CTRL_WMASK);
        SEL_DCACHE: dcache_q <= wdata_i[NUM_RGN-1:0];
        SEL_ICACHE: icache_q <= wdata_i[NUM_RGN-1:0];
        SEL_WBUF:   wbuf_q   <= wdata_i[NUM_RGN-1:0];
        SEL_DPERM:  dperm_q  <= wdata_i[PERM_W-1:0];
        SEL_CPERM:  cperm_q  <= wdata_i[PERM_W-1:0];
        SEL_DLEG:   dperm_q  <= leg_wr;
        SEL_CLEG:   cperm_q  <= leg_wr;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic [DW-1:0] desc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        desc_q <= '0;
      else if (we_i && sel_i == SEL_RGN && idx_i == IDX_W'(g))
        desc_q <= wdata_i;
    end
    assign rgn_o[g] = desc_q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL:   rdata_o = ctrl_q;
      SEL_DCACHE: rdata_o = DW'(dcache_q);
      SEL_ICACHE: rdata_o = DW'(icache_q);
      SEL_WBUF:   rdata_o = DW'(wbuf_q);
      SEL_DPERM:  rdata_o = DW'(dperm_q);
      SEL_CPERM:  rdata_o = DW'(cperm_q);
      SEL_DLEG:   rdata_o = DW'(dleg_rd);
      SEL_CLEG:   rdata_o = DW'(cleg_rd);
      SEL_RGN:    rdata_o = rgn_o[idx_i];
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign dcache_o = dcache_q;
  assign icache_o = icache_q;
  assign wbuf_o   = wbuf_q;
  assign dperm_o  = dperm_q;
  assign cperm_o  = cperm_q;

  assert_ctrl_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ctrl_q & ~CTRL_WMASK));

  assert_legacy_clears_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DLEG) |=> ((dperm_q & LEG_HI) == '0));

  assert_rsvd_sel_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i > SEL_RGN) |=> ($stable(dperm_q) && $stable(cperm_q) && $stable(ctrl_q)));
endmodule

// File: rtl/mpu_match.sv
module mpu_match
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_RGN = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_RGN),
  localparam int unsigned PG_W   = DW - PAGE_W
) (
  input  logic [DW-1:0]              addr_i,
  input  logic [NUM_RGN-1:0][DW-1:0] rgn_i,
  output logic [NUM_RGN-1:0]         hit_vec_o,
  output logic [NUM_RGN-1:0]         win_oh_o,
  output logic                       win_vld_o,
  output logic [IDX_W-1:0]           win_idx_o
);
  logic [PG_W-1:0] addr_pg;
  assign addr_pg = addr_i[DW-1:PAGE_W];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    logic [4:0]      exp_n;
    logic [PG_W-1:0] base_pg;
    logic [PG_W:0]   span, end_pg;
    assign exp_n   = rgn_i[g][5:1];
    assign base_pg = rgn_i[g][DW-1:PAGE_W];
    assign span    = (exp_n >= 5'(MIN_EXP)) ? ((PG_W+1)'(1) << (exp_n - 5'(MIN_EXP))) : '0;
    assign end_pg  = {1'b0, base_pg} + span;
    assign hit_vec_o[g] = rgn_i[g][0] && (span != '0) && (addr_pg >= base_pg)
                          && ({1'b0, addr_pg} < end_pg);
  end

  // highest index wins
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_oh_o  = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (hit_vec_o[i]) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
      end
    end
    if (win_vld_o) win_oh_o[win_idx_o] = 1'b1;
  end
endmodule

// File: rtl/mpu_perm.sv
module mpu_perm
  import mpu_pkg::*;
(
  input  logic [3:0] dcode_i,
  input  logic [3:0] ccode_i,
  input  logic       priv_i,
  input  logic [1:0] type_i,
  output logic       allow_o
);
  logic p_rd, p_wr, u_rd, u_wr, p_ex, u_ex;

  always_comb begin
    {p_rd, p_wr, u_rd, u_wr} = 4'b0000;
    unique case (dcode_i)
      4'd1:    {p_rd, p_wr, u_rd, u_wr} = 4'b1100;
      4'd2:    {p_rd, p_wr, u_rd, u_wr} = 4'b1110;
      4'd3:    {p_rd, p_wr, u_rd, u_wr} = 4'b1111;
      4'd5:    {p_rd, p_wr, u_rd, u_wr} = 4'b1000;
      4'd6:    {p_rd, p_wr, u_rd, u_wr} = 4'b1010;
      default: {p_rd, p_wr, u_rd, u_wr} = 4'b0000;
    endcase
    unique case (ccode_i)
      4'd1, 4'd5:       {p_ex, u_ex} = 2'b10;
      4'd2, 4'd3, 4'd6: {p_ex, u_ex} = 2'b11;
      default:          {p_ex, u_ex} = 2'b00;
    endcase
  end

  always_comb begin
    unique case (acc_e'(type_i))
      ACC_FETCH: allow_o = priv_i ? p_ex : u_ex;
      ACC_WRITE: allow_o = priv_i ? p_wr : u_wr;
      default:   allow_o = priv_i ? p_rd : u_rd;
    endcase
  end
endmodule

// File: rtl/region_prot_unit.sv
module region_prot_unit
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_RGN = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_RGN),
  localparam int unsigned PERM_W = 4 * NUM_RGN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_sel_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [DW-1:0]    cfg_rdata_o,
  input  logic             acc_valid_i,
  input  logic [DW-1:0]    acc_addr_i,
  input  logic             acc_priv_i,
  input  logic [1:0]       acc_type_i,
  output logic             chk_valid_o,
  output logic             chk_abort_o,
  output logic             chk_cacheable_o,
  output logic             chk_bufferable_o,
  output logic             chk_hit_o,
  output logic [IDX_W-1:0] chk_region_o,
  output logic [DW-1:0]    vec_base_o
);
  logic [DW-1:0]              ctrl;
  logic [NUM_RGN-1:0]         dcache, icache, wbuf;
  logic [PERM_W-1:0]          dperm, cperm;
  logic [NUM_RGN-1:0][DW-1:0] rgn;
  logic [NUM_RGN-1:0]         hit_vec, win_oh;
  logic                       win_vld;
  logic [IDX_W-1:0]           win_idx;
  logic                       allow;
  logic                       is_fetch;
  logic                       abort_d, cache_d, buf_d, hit_d;
  logic [IDX_W-1:0]           rgn_d;

  mpu_regs #(.NUM_RGN(NUM_RGN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ctrl_o  (ctrl),
    .dcache_o(dcache),
    .icache_o(icache),
    .wbuf_o  (wbuf),
    .dperm_o (dperm),
    .cperm_o (cperm),
    .rgn_o   (rgn)
  );

  mpu_match #(.NUM_RGN(NUM_RGN)) u_match (
    .addr_i   (acc_addr_i),
    .rgn_i    (rgn),
    .hit_vec_o(hit_vec),
    .win_oh_o (win_oh),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx)
  );

  mpu_perm u_perm (
    .dcode_i(dperm[{win_idx, 2'b00} +: 4]),
    .ccode_i(cperm[{win_idx, 2'b00} +: 4]),
    .priv_i (acc_priv_i),
    .type_i (acc_type_i),
    .allow_o(allow)
  );

  assign is_fetch   = (acc_e'(acc_type_i) == ACC_FETCH);
  assign vec_base_o = ctrl[BIT_VEC] ? VEC_HIGH : '0;

  always_comb begin
    abort_d = 1'b0;
    cache_d = 1'b0;
    buf_d   = 1'b0;
    hit_d   = 1'b0;
    rgn_d   = '0;
    if (!ctrl[BIT_EN]) begin
      cache_d = is_fetch ? ctrl[BIT_ICACHE] : ctrl[BIT_DCACHE];
      buf_d   = !is_fetch && ctrl[BIT_DCACHE];
    end else if (!win_vld) begin
      abort_d = 1'b1;
    end else begin
      hit_d   = 1'b1;
      rgn_d   = win_idx;
      abort_d = !allow;
      if (is_fetch) begin
        cache_d = ctrl[BIT_ICACHE] && icache[win_idx];
      end else begin
        cache_d = ctrl[BIT_DCACHE] && dcache[win_idx];
        buf_d   = cache_d && wbuf[win_idx];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o      <= 1'b0;
      chk_abort_o      <= 1'b0;
      chk_cacheable_o  <= 1'b0;
      chk_bufferable_o <= 1'b0;
      chk_hit_o        <= 1'b0;
      chk_region_o     <= '0;
    end else begin
      chk_valid_o <= acc_valid_i;
      if (acc_valid_i) begin
        chk_abort_o      <= abort_d;
        chk_cacheable_o  <= cache_d;
        chk_bufferable_o <= buf_d;
        chk_hit_o        <= hit_d;
        chk_region_o     <= rgn_d;
      end
    end
  end

  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> chk_valid_o);

  assert_valid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !chk_valid_o);

  assert_single_winner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh) && (win_vld == (hit_vec != '0)));

  assert_buf_needs_cache_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_bufferable_o |-> chk_cacheable_o);

  assert_fetch_unbuffered_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && is_fetch) |=> !chk_bufferable_o);

  assert_off_allows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !ctrl[BIT_EN]) |=> !chk_abort_o);

  assert_nomatch_aborts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && ctrl[BIT_EN] && hit_vec == '0) |=> (chk_abort_o && !chk_cacheable_o));
endmodule

// File: tb/sim_region_prot_unit.sv
module sim_region_prot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0;
  logic [1:0]  acc_type = '0;
  logic        chk_valid, chk_abort, chk_cache, chk_buf, chk_hit;
  logic [2:0]  chk_rgn;
  logic [31:0] vec_base;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  logic [7:0]  m_dc, m_ic, m_wb;
  logic [31:0] m_dp, m_cp;
  logic [31:0] m_rgn [8];
  bit          pend_valid = 0;

  always #4 clk = ~clk;

  region_prot_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_priv_i(acc_priv),
    .acc_type_i(acc_type), .chk_valid_o(chk_valid), .chk_abort_o(chk_abort),
    .chk_cacheable_o(chk_cache), .chk_bufferable_o(chk_buf), .chk_hit_o(chk_hit),
    .chk_region_o(chk_rgn), .vec_base_o(vec_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R11: valid tracks the request of the previous clock, checked every clock
  always @(posedge clk) pend_valid <= rst_n && acc_valid;
  always @(negedge clk) if (rst_n && !done) check("R11 valid", {31'd0, chk_valid}, {31'd0, pend_valid});

  function automatic logic [31:0] model_read(input int sel, input int idx);
    logic [31:0] r = '0;
    case (sel)
      0: r = m_ctrl;
      1: r = {24'd0, m_dc};
      2: r = {24'd0, m_ic};
      3: r = {24'd0, m_wb};
      4: r = m_dp;
      5: r = m_cp;
      6: for (int i = 0; i < 8; i++) r[2*i +: 2] = m_dp[4*i +: 2];
      7: for (int i = 0; i < 8; i++) r[2*i +: 2] = m_cp[4*i +: 2];
      8: r = m_rgn[idx];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic wr(input int sel, input int idx, input logic [31:0] d);
    logic [31:0] p;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    p = '0;
    for (int i = 0; i < 8; i++) p[4*i +: 2] = d[2*i +: 2];
    case (sel)
      0: m_ctrl = (m_ctrl & ~32'h000F_F085) | (d & 32'h000F_F085);
      1: m_dc = d[7:0];
      2: m_ic = d[7:0];
      3: m_wb = d[7:0];
      4: m_dp = d;
      5: m_cp = d;
      6: m_dp = p;
      7: m_cp = p;
      8: m_rgn[idx] = d;
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input int sel, input int idx);
    @(negedge clk);
    cfg_sel = 4'(sel); cfg_idx = 3'(idx);
    #1;
    check(req, cfg_rdata, model_read(sel, idx));
  endtask

  function automatic bit data_ok(input int c, input bit pv, input bit w);
    bit pr = (c == 1 || c == 2 || c == 3 || c == 5 || c == 6);
    bit pw = (c == 1 || c == 2 || c == 3);
    bit ur = (c == 2 || c == 3 || c == 6);
    bit uw = (c == 3);
    if (w) return pv ? pw : uw;
    return pv ? pr : ur;
  endfunction

  function automatic bit code_ok(input int c, input bit pv);
    if (c == 2 || c == 3 || c == 6) return 1'b1;
    if (c == 1 || c == 5) return pv;
    return 1'b0;
  endfunction

  task automatic model(input logic [31:0] a, input bit pv, input int ty,
                       output bit ab, output bit ca, output bit bu, output bit ht, output int rg);
    longint lo, hi;
    int n;
    bit fetch = (ty == 2);
    ab = 0; ca = 0; bu = 0; ht = 0; rg = 0;
    if (!m_ctrl[0]) begin
      ca = fetch ? m_ctrl[12] : m_ctrl[2];
      bu = !fetch && m_ctrl[2];
      return;
    end
    for (int r = 7; r >= 0 && !ht; r--) begin
      n  = int'(m_rgn[r][5:1]);
      lo = longint'(m_rgn[r][31:12]) * 4096;
      hi = lo + (longint'(2) << n);
      if (m_rgn[r][0] && n >= 11 && longint'(a) >= lo && longint'(a) < hi) begin
        ht = 1; rg = r;
      end
    end
    if (!ht) begin ab = 1; return; end
    if (fetch) begin
      ab = !code_ok(int'(m_cp[4*rg +: 4]), pv);
      ca = m_ctrl[12] && m_ic[rg];
    end else begin
      ab = !data_ok(int'(m_dp[4*rg +: 4]), pv, ty == 1);
      ca = m_ctrl[2] && m_dc[rg];
      bu = ca && m_wb[rg];
    end
  endtask

  task automatic acc(input string req, input logic [31:0] a, input bit pv, input int ty);
    bit ab, ca, bu, ht;
    int rg;
    model(a, pv, ty, ab, ca, bu, ht, rg);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_priv = pv; acc_type = 2'(ty);
    @(negedge clk);
    acc_valid = 1'b0;
    check({req, " abort"}, {31'd0, chk_abort}, {31'd0, ab});
    check({req, " cacheable"}, {31'd0, chk_cache}, {31'd0, ca});
    check({req, " bufferable"}, {31'd0, chk_buf}, {31'd0, bu});
    check({req, " hit"}, {31'd0, chk_hit}, {31'd0, ht});
    check({req, " region"}, {29'd0, chk_rgn}, 32'(rg));
  endtask

  task automatic sweep(input string req, input logic [31:0] a);
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 2; p++) acc(req, a, p[0], t);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    m_ctrl = 32'h0000_2078; m_dc = 0; m_ic = 0; m_wb = 0; m_dp = 0; m_cp = 0;
    for (int i = 0; i < 8; i++) m_rgn[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 vec_base", vec_base, 32'hFFFF_0000);
    check("R1 chk_valid", {31'd0, chk_valid}, 32'd0);
    for (int s = 0; s < 8; s++) rd("R1 reset read", s, 0);
    for (int i = 0; i < 8; i++) rd("R1 region reset", 8, i);

    // R2 control masking and vector base
    wr(0, 0, 32'hFFFF_FFFF);
    rd("R2 ctrl all ones", 0, 0);
    check("R2 vec high", vec_base, 32'hFFFF_0000);
    wr(0, 0, 32'h0000_0000);
    rd("R2 ctrl zero", 0, 0);
    check("R2 vec low", vec_base, 32'h0000_0000);

    // R10 unit disabled
    sweep("R10 off no cache", 32'h1234_5678);
    wr(0, 0, 32'h0000_1004);
    sweep("R10 off cache gates", 32'h0200_0000);

    // R12 reserved selects
    for (int s = 9; s < 16; s++) begin
      wr(s, 0, 32'hFFFF_FFFF);
      rd("R12 reserved read", s, 0);
    end
    for (int s = 0; s < 9; s++) rd("R12 no side effect", s, 0);

    // R3/R4 nested layout
    wr(8, 0, 32'h0000_003F);                        // whole space
    wr(8, 1, 32'h0200_0000 | (23 << 1) | 1);        // 16 MB
    wr(8, 2, 32'h027F_F000 | (11 << 1) | 1);        // one page
    wr(8, 3, 32'h0300_0000 | (10 << 1) | 1);        // too small: empty
    wr(8, 4, 32'h8000_0000 | (31 << 1) | 1);        // runs past top
    wr(8, 5, 32'h0400_0000 | (20 << 1) | 0);        // disabled
    wr(8, 7, 32'h0200_0000 | (12 << 1) | 1);        // 8 KB over region 1
    for (int i = 0; i < 8; i++) rd("R3 descriptor read", 8, i);
    wr(4, 0, 32'h6532_1653);
    wr(5, 0, 32'h1236_5213);
    wr(0, 0, 32'h0000_0001);
    acc("R4 top region wins", 32'h0200_0000, 1, 0);
    acc("R4 top region last byte", 32'h0200_1FFF, 0, 0);
    acc("R3 region1 after top", 32'h0200_2000, 1, 1);
    acc("R3 region1 last byte", 32'h02FF_FFFF, 1, 0);
    acc("R3 region1 end", 32'h0300_0000, 1, 0);
    acc("R3 page region", 32'h027F_F800, 1, 1);
    acc("R3 below page", 32'h027F_EFFC, 1, 1);
    acc("R3 small region empty", 32'h0300_0010, 1, 2);
    acc("R3 disabled region", 32'h0400_0000, 1, 0);
    acc("R3 wrap region top", 32'hFFFF_FFFF, 0, 0);
    acc("R3 wrap region base", 32'h8000_0000, 1, 2);

    // R7 no match
    wr(8, 0, 32'h0000_003E);
    sweep("R7 uncovered", 32'h0100_0000);
    sweep("R7 covered", 32'h0200_0100);

    // R5/R6 code sweep on region 7
    for (int c = 0; c < 16; c++) begin
      wr(4, 0, (m_dp & 32'h0FFF_FFFF) | (32'(c) << 28));
      wr(5, 0, (m_cp & 32'h0FFF_FFFF) | (32'(c) << 28));
      sweep("R5 R6 code sweep", 32'h0200_0040);
    end

    // R8 legacy views
    wr(6, 0, 32'h0000_FFFF);
    rd("R8 data full after legacy", 4, 0);
    rd("R8 data legacy read", 6, 0);
    wr(5, 0, 32'h6543_21F6);
    rd("R8 code legacy read", 7, 0);
    wr(7, 0, 32'h0000_1B6C);
    rd("R8 code full after legacy", 5, 0);
    sweep("R8 legacy perms active", 32'h0200_0040);

    // R9 cache attributes
    wr(1, 0, 32'h0000_0082);
    wr(2, 0, 32'h0000_0090);
    wr(3, 0, 32'h0000_0080);
    wr(4, 0, 32'h3333_3333);
    wr(5, 0, 32'h2222_2222);
    sweep("R9 gates off", 32'h0200_0040);
    wr(0, 0, 32'h0000_1005);
    sweep("R9 region7 cached", 32'h0200_0040);
    sweep("R9 region1 no wbuf", 32'h0210_0000);
    sweep("R9 region4 code", 32'h9000_0000);
    wr(0, 0, 32'h0000_0005);
    sweep("R9 code gate off", 32'h9000_0000);

    // R11 idle cycle after a request
    acc("R11 single", 32'h0200_0040, 1, 0);
    @(negedge clk);
    check("R11 idle", {31'd0, chk_valid}, 32'd0);

    // random addresses around boundaries
    wr(8, 0, 32'h0000_003F);
    wr(0, 0, 32'h0000_1005);
    wr(4, 0, 32'h6152_3165);
    wr(5, 0, 32'h5126_0312);
    pool[0] = 32'h0200_0000; pool[1] = 32'h0300_0000; pool[2] = 32'h027F_F000;
    pool[3] = 32'h8000_0000; pool[4] = 32'h0200_2000; pool[5] = 32'h0000_0000;
    pool[6] = 32'hFFFF_F000; pool[7] = 32'h0400_0000;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r = $urandom;
      acc("R4 random", pool[r[2:0]] + {20'd0, r[14:3]} - 32'(r[15] ? 32'h1000 : 0),
          r[16], int'(r[18:17]));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule